// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This block compares a stream of signed integer elements and writes one result bit per element into a mask register. Each compare either pairs two vector operands element by element, or tests every element against one broadcast scalar. A compare command is a one-cycle `start_i` pulse. It carries a condition code, the operand form, the scalar and the vector length (VL). After the command, elements arrive on a valid-qualified stream. The unit takes one element in each cycle that the stream is valid. Element i sets or clears mask bit i. When the final element has been taken, every mask bit at position VL or higher is forced to zero, and `done_o` pulses once.

The stored mask then gates a later element-wise operation. An arithmetic stream presents an element index and a valid flag. The unit returns a write enable that is high only for elements whose mask bit is 1, so an all-ones mask lets every element through.

Control is a three-state machine. ST_IDLE waits for a command. ST_RUN takes elements. ST_FINISH is the single done cycle. The transitions are named as follows:
- IDLE_TO_RUN: `start_i` arrives in ST_IDLE with a nonzero length.
- IDLE_TO_FINISH: `start_i` arrives in ST_IDLE with a zero length.
- RUN_TO_FINISH: the element at index VL-1 is accepted.
- FINISH_TO_IDLE: taken unconditionally after one cycle.

Top module: `vec_cmp_mask`

## Requirements
- R1: Condition codes select signed two's-complement relations of operand A to operand B: 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal, 5 less-or-equal. A true relation stores 1 in the element's mask bit and a false one stores 0.
- R2: Condition codes 6 and 7 are reserved and always store 0.
- R3: With `scalar_mode_i`=1 at the command, every element A is compared against the latched `scalar_i`, and `elem_b_i` has no effect. With `scalar_mode_i`=0, A is compared against `elem_b_i`.
- R4: Only cycles with `elem_valid_i` high in ST_RUN consume an element. The k-th consumed element (k from 0) writes mask bit k. Stall cycles do not advance the index.
- R5: `done_o` is high for exactly the one cycle after the clock edge that accepts element VL-1. `busy_o` is high from the cycle after the command up to and including that done cycle.
- R6: On completion, all mask bits at index VL and above read 0.
- R7: A command with VL=0 gives `done_o` in the cycle after the command and leaves the whole mask at 0.
- R8: A VL larger than the maximum vector length (64 by default) is treated as the maximum.
- R9: `start_i` is ignored while `busy_o` is high, including in the done cycle. It affects neither the length, the condition nor the element count.
- R10: `op_en_o` equals `op_valid_i` ANDed with `mask_o[op_idx_i]`. With an all-ones mask, every valid element is enabled.
- R11: After reset, `mask_o` is 0 and `busy_o` and `done_o` are 0.
- R12: Outside a running compare, the mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command pulse, taken only in ST_IDLE |
| cond_i | input | 3 | Relation code (R1, R2) |
| scalar_mode_i | input | 1 | 1 = compare elements against scalar |
| vl_i | input | 7 | Vector length, 0..127, clamped to 64 |
| scalar_i | input | 64 | Broadcast scalar operand |
| elem_valid_i | input | 1 | Element pair valid |
| elem_a_i | input | 64 | Element operand A |
| elem_b_i | input | 64 | Element operand B |
| op_valid_i | input | 1 | Consumer element valid |
| op_idx_i | input | 6 | Consumer element index |
| busy_o | output | 1 | Compare in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mask_o | output | 64 | Mask register contents |
| op_en_o | output | 1 | Mask-gated write enable |

## Verification
The bench uses signed operand pairs that straddle the sign boundary. An unsigned comparator would invert greater and less on exactly these pairs. It runs a full-length all-ones compare followed by a short one. A unit that skipped the clearing of high bits would leave stale ones above VL. The bench also covers:
- Stalls between elements. If a stall advanced the index, bits would be written at the wrong positions and `done_o` would come early.
- A zero length. A unit that waited for an element would hang.
- An oversize length. The run must stop after 64 elements.
- `start_i` pulses in mid-run and during the done cycle. A unit that accepted them would restart the run or produce a second done pulse.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    localparam logic [2:0] REL_EQ = 3'd0;
    localparam logic [2:0] REL_NE = 3'd1;
    localparam logic [2:0] REL_GT = 3'd2;
    localparam logic [2:0] REL_LT = 3'd3;
    localparam logic [2:0] REL_GE = 3'd4;
    localparam logic [2:0] REL_LE = 3'd5;

    localparam int REL_CODES = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } vcm_state_e;

endpackage

// File: rtl/vcm_compare.sv
module vcm_compare
    import vcm_pkg::*;
#(
    parameter int ELEM_W = 64
) (
    input  logic [2:0]        cond_i,
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    output logic              hit_o
);

    logic              is_eq;
    logic              is_lt;
    logic [REL_CODES-1:0] rel;

    assign is_eq = (a_i == b_i);
    assign is_lt = ($signed(a_i) < $signed(b_i));

    // One relation per code; the reserved codes evaluate to false.
    for (genvar g = 0; g < REL_CODES; g++) begin : g_rel
        if (g == int'(REL_EQ)) begin : g_eq
            assign rel[g] = is_eq;
        end else if (g == int'(REL_NE)) begin : g_ne
            assign rel[g] = ~is_eq;
        end else if (g == int'(REL_GT)) begin : g_gt
            assign rel[g] = ~is_lt & ~is_eq;
        end else if (g == int'(REL_LT)) begin : g_lt
            assign rel[g] = is_lt;
        end else if (g == int'(REL_GE)) begin : g_ge
            assign rel[g] = ~is_lt;
        end else if (g == int'(REL_LE)) begin : g_le
            assign rel[g] = is_lt | is_eq;
        end else begin : g_rsv
            assign rel[g] = 1'b0;
        end
    end

    always_comb begin
        hit_o = rel[cond_i];
    end

endmodule

// File: rtl/vcm_mask_reg.sv
module vcm_mask_reg #(
    parameter int MVL = 64,
    parameter int IW  = 6,
    parameter int LW  = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [IW-1:0]  wr_idx_i,
    input  logic           wr_bit_i,
    input  logic           trim_en_i,
    input  logic [LW-1:0]  trim_len_i,
    input  logic           op_valid_i,
    input  logic [IW-1:0]  op_idx_i,
    output logic [MVL-1:0] mask_o,
    output logic           op_en_o
);

    logic [MVL-1:0] keep;
    logic [MVL-1:0] mask_q;
    logic [MVL-1:0] mask_d;

    // Positions below the trim length survive a completion.
    for (genvar g = 0; g < MVL; g++) begin : g_keep
        assign keep[g] = (trim_len_i > LW'(g));
    end

    always_comb begin
        mask_d = mask_q;
        if (wr_en_i) begin
            mask_d[wr_idx_i] = wr_bit_i;
        end
        if (trim_en_i) begin
            mask_d = mask_d & keep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o  = mask_q;
    assign op_en_o = op_valid_i & mask_q[op_idx_i];

    p_trim_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trim_en_i |=> ((mask_q & ~$past(keep)) == '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !trim_en_i) |=> $stable(mask_q));

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !trim_en_i) |=> (mask_q[$past(wr_idx_i)] == $past(wr_bit_i)));

    p_gate_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_en_o |-> op_valid_i);

endmodule

// File: rtl/vcm_ctrl.sv
module vcm_ctrl
    import vcm_pkg::*;
#(
    parameter int ELEM_W = 64,
    parameter int MVL    = 64,
    parameter int IW     = 6,
    parameter int LW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        cond_i,
    input  logic              scalar_mode_i,
    input  logic [LW-1:0]     vl_i,
    input  logic [ELEM_W-1:0] scalar_i,
    input  logic              elem_valid_i,
    output logic [2:0]        cond_o,
    output logic              scalar_mode_o,
    output logic [ELEM_W-1:0] scalar_o,
    output logic              wr_en_o,
    output logic [IW-1:0]     wr_idx_o,
    output logic              trim_en_o,
    output logic [LW-1:0]     trim_len_o,
    output logic              busy_o,
    output logic              done_o
);

    vcm_state_e        state_q;
    vcm_state_e        state_d;
    logic [IW-1:0]     idx_q;
    logic [LW-1:0]     vl_q;
    logic [2:0]        cond_q;
    logic              smode_q;
    logic [ELEM_W-1:0] scalar_q;

    logic [LW-1:0]     vl_clamped;
    logic              take_cmd;
    logic              accept;
    logic              last;

    assign vl_clamped = (vl_i > LW'(MVL)) ? LW'(MVL) : vl_i;
    assign take_cmd   = (state_q == ST_IDLE) && start_i;
    assign accept     = (state_q == ST_RUN) && elem_valid_i;
    assign last       = accept && (LW'(idx_q) == (vl_q - LW'(1)));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (vl_clamped == '0) ? ST_FINISH : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            vl_q     <= '0;
            cond_q   <= '0;
            smode_q  <= 1'b0;
            scalar_q <= '0;
        end else if (take_cmd) begin
            idx_q    <= '0;
            vl_q     <= vl_clamped;
            cond_q   <= cond_i;
            smode_q  <= scalar_mode_i;
            scalar_q <= scalar_i;
        end else if (accept) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    always_comb begin
        busy_o        = (state_q != ST_IDLE);
        done_o        = (state_q == ST_FINISH);
        wr_en_o       = accept;
        wr_idx_o      = idx_q;
        trim_en_o     = last || (take_cmd && (vl_clamped == '0));
        trim_len_o    = (state_q == ST_IDLE) ? vl_clamped : vl_q;
        cond_o        = cond_q;
        scalar_mode_o = smode_q;
        scalar_o      = scalar_q;
    end

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(vl_q) && $stable(cond_q) && $stable(smode_q)));

    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (LW'(idx_q) < vl_q));

    p_len_clamped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (vl_q <= LW'(MVL)));

    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cmd && (vl_i == '0)) |=> done_o);

endmodule

// File: rtl/vec_cmp_mask.sv
module vec_cmp_mask #(
    parameter  int ELEM_W = 64,
    parameter  int MVL    = 64,
    localparam int IW     = (MVL > 1) ? $clog2(MVL) : 1,
    localparam int LW     = $clog2(MVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        cond_i,
    input  logic              scalar_mode_i,
    input  logic [LW-1:0]     vl_i,
    input  logic [ELEM_W-1:0] scalar_i,
    input  logic              elem_valid_i,
    input  logic [ELEM_W-1:0] elem_a_i,
    input  logic [ELEM_W-1:0] elem_b_i,
    input  logic              op_valid_i,
    input  logic [IW-1:0]     op_idx_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [MVL-1:0]    mask_o,
    output logic              op_en_o
);

    logic [2:0]        cond_q;
    logic              smode_q;
    logic [ELEM_W-1:0] scalar_q;
    logic              wr_en;
    logic [IW-1:0]     wr_idx;
    logic              trim_en;
    logic [LW-1:0]     trim_len;
    logic [ELEM_W-1:0] rhs;
    logic              hit;

    vcm_ctrl #(
        .ELEM_W (ELEM_W),
        .MVL    (MVL),
        .IW     (IW),
        .LW     (LW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cond_i        (cond_i),
        .scalar_mode_i (scalar_mode_i),
        .vl_i          (vl_i),
        .scalar_i      (scalar_i),
        .elem_valid_i  (elem_valid_i),
        .cond_o        (cond_q),
        .scalar_mode_o (smode_q),
        .scalar_o      (scalar_q),
        .wr_en_o       (wr_en),
        .wr_idx_o      (wr_idx),
        .trim_en_o     (trim_en),
        .trim_len_o    (trim_len),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    assign rhs = smode_q ? scalar_q : elem_b_i;

    vcm_compare #(
        .ELEM_W (ELEM_W)
    ) u_cmp (
        .cond_i (cond_q),
        .a_i    (elem_a_i),
        .b_i    (rhs),
        .hit_o  (hit)
    );

    vcm_mask_reg #(
        .MVL (MVL),
        .IW  (IW),
        .LW  (LW)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_bit_i   (hit),
        .trim_en_i  (trim_en),
        .trim_len_i (trim_len),
        .op_valid_i (op_valid_i),
        .op_idx_i   (op_idx_i),
        .mask_o     (mask_o),
        .op_en_o    (op_en_o)
    );

    p_busy_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

endmodule

// File: tb/vec_cmp_mask_test.sv
module vec_cmp_mask_test;

    localparam int W   = 64;
    localparam int MVL = 64;
    localparam logic [63:0] M1  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] M2  = 64'hFFFF_FFFF_FFFF_FFFE;
    localparam logic [63:0] MIN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAX = 64'h7FFF_FFFF_FFFF_FFFF;

    // {cond, a, b, expected bit}
    localparam int NT = 16;
    localparam logic [131:0] TBL [NT] = '{
        {3'd0, 64'd5, 64'd5, 1'b1},
        {3'd0, 64'd5, 64'd6, 1'b0},
        {3'd1, 64'd5, 64'd6, 1'b1},
        {3'd1, M1,    M1,    1'b0},
        {3'd2, 64'd1, M1,    1'b1},
        {3'd2, M1,    64'd1, 1'b0},
        {3'd3, MIN,   MAX,   1'b1},
        {3'd3, 64'd7, 64'd7, 1'b0},
        {3'd4, 64'd7, 64'd7, 1'b1},
        {3'd4, M2,    M1,    1'b0},
        {3'd5, M2,    M1,    1'b1},
        {3'd5, 64'd3, 64'd2, 1'b0},
        {3'd6, 64'd5, 64'd5, 1'b0},
        {3'd7, 64'd1, 64'd0, 1'b0},
        {3'd2, MAX,   MIN,   1'b1},
        {3'd5, 64'd0, 64'd0, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [2:0]     cond_i = '0;
    logic           scalar_mode_i = 1'b0;
    logic [6:0]     vl_i = '0;
    logic [W-1:0]   scalar_i = '0;
    logic           elem_valid_i = 1'b0;
    logic [W-1:0]   elem_a_i = '0;
    logic [W-1:0]   elem_b_i = '0;
    logic           op_valid_i = 1'b0;
    logic [5:0]     op_idx_i = '0;
    logic           busy_o;
    logic           done_o;
    logic [MVL-1:0] mask_o;
    logic           op_en_o;

    int n_chk  = 0;
    int n_fail = 0;

    vec_cmp_mask #(.ELEM_W(W), .MVL(MVL)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cond_i        (cond_i),
        .scalar_mode_i (scalar_mode_i),
        .vl_i          (vl_i),
        .scalar_i      (scalar_i),
        .elem_valid_i  (elem_valid_i),
        .elem_a_i      (elem_a_i),
        .elem_b_i      (elem_b_i),
        .op_valid_i    (op_valid_i),
        .op_idx_i      (op_idx_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .mask_o        (mask_o),
        .op_en_o       (op_en_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] c, input logic sm, input logic [63:0] s, input logic [6:0] len);
        @(negedge clk);
        start_i = 1'b1; cond_i = c; scalar_mode_i = sm; scalar_i = s; vl_i = len;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic feed(input logic [63:0] a, input logic [63:0] b);
        elem_valid_i = 1'b1; elem_a_i = a; elem_b_i = b;
        @(negedge clk);
        elem_valid_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(mask_o == '0, "R11 mask", mask_o, 64'd0);
        chk(!busy_o && !done_o, "R11 busy/done", {62'd0, busy_o, done_o}, 64'd0);
        rst_n = 1'b1;

        // R1 / R2: table walk, one-element compares
        for (int i = 0; i < NT; i++) begin
            cmd(TBL[i][131:129], 1'b0, 64'd0, 7'd1);
            feed(TBL[i][128:65], TBL[i][64:1]);
            chk(done_o == 1'b1, "R5 done after last", {63'd0, done_o}, 64'd1);
            chk(mask_o == {63'd0, TBL[i][0]},
                (TBL[i][131:129] > 3'd5) ? "R2 reserved code" : "R1 relation",
                mask_o, {63'd0, TBL[i][0]});
            @(negedge clk);
            chk(done_o == 1'b0, "R5 done one cycle", {63'd0, done_o}, 64'd0);
        end

        // R3 / R4: vector-scalar GT 10, b stream ignored
        cmd(3'd2, 1'b1, 64'd10, 7'd8);
        for (int i = 0; i < 8; i++) begin
            feed(64'(i * 3 - 4), 64'd1000);
        end
        chk(mask_o == 64'hE0, "R3 vector-scalar", mask_o, 64'hE0);

        // R4 / R5: stalls between elements, LT against 2
        cmd(3'd3, 1'b0, 64'd0, 7'd4);
        for (int i = 0; i < 4; i++) begin
            repeat (2) @(negedge clk);
            chk(busy_o && !done_o, "R4 stall no progress", {62'd0, busy_o, done_o}, 64'd2);
            feed(64'(i), 64'd2);
        end
        chk(done_o && mask_o == 64'h3, "R4 stalled stream", mask_o, 64'h3);
        @(negedge clk);
        chk(!busy_o, "R5 busy drops", {63'd0, busy_o}, 64'd0);

        // Full-length all-true compare, then R10 all ones enable
        cmd(3'd0, 1'b0, 64'd0, 7'd64);
        for (int i = 0; i < 64; i++) feed(64'(i), 64'(i));
        chk(mask_o == M1, "R1 full length EQ", mask_o, M1);
        op_valid_i = 1'b1;
        for (int i = 0; i < 64; i++) begin
            op_idx_i = 6'(i);
            #1;
            chk(op_en_o == 1'b1, "R10 all ones", {63'd0, op_en_o}, 64'd1);
        end
        op_valid_i = 1'b0;

        // R6: short compare trims stale high bits
        cmd(3'd1, 1'b0, 64'd0, 7'd5);
        for (int i = 0; i < 5; i++) feed(64'(i), 64'(i + 1));
        chk(mask_o == 64'h1F, "R6 upper bits cleared", mask_o, 64'h1F);

        // R12: mask holds while idle, even with stream activity
        repeat (3) @(negedge clk);
        feed(64'd9, 64'd9);
        repeat (3) @(negedge clk);
        chk(mask_o == 64'h1F, "R12 mask held", mask_o, 64'h1F);

        // R10: gating by index
        #1;
        chk(op_en_o == 1'b0, "R10 invalid gives no enable", {63'd0, op_en_o}, 64'd0);
        op_valid_i = 1'b1;
        for (int i = 0; i < 64; i++) begin
            op_idx_i = 6'(i);
            #1;
            chk(op_en_o == (i < 5), "R10 gated enable", {63'd0, op_en_o}, 64'(i < 5));
        end
        op_valid_i = 1'b0;

        // R7: zero length
        cmd(3'd0, 1'b0, 64'd0, 7'd0);
        chk(done_o && mask_o == '0, "R7 zero length", mask_o, 64'd0);
        @(negedge clk);

        // R8: oversize length clamps to 64
        cmd(3'd4, 1'b0, 64'd0, 7'd100);
        for (int i = 0; i < 64; i++) begin
            if (i == 63) chk(!done_o, "R8 no early done", {63'd0, done_o}, 64'd0);
            feed(64'd1, 64'd1);
        end
        chk(done_o && mask_o == M1, "R8 clamp to max", mask_o, M1);
        @(negedge clk);
        chk(!busy_o, "R8 run ends", {63'd0, busy_o}, 64'd0);

        // R9: start while busy ignored
        cmd(3'd4, 1'b0, 64'd0, 7'd4);
        feed(64'd1, 64'd0);
        start_i = 1'b1; cond_i = 3'd0; vl_i = 7'd1;
        @(negedge clk);
        start_i = 1'b0;
        feed(64'd0, 64'd0);
        chk(!done_o && busy_o, "R9 mid-run start ignored", {62'd0, busy_o, done_o}, 64'd2);
        feed(M1, 64'd0);
        feed(64'd5, 64'd5);
        chk(done_o && mask_o == 64'hB, "R9 run intact", mask_o, 64'hB);
        start_i = 1'b1; vl_i = 7'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o && !busy_o, "R9 start in done cycle ignored", {62'd0, busy_o, done_o}, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule